// File: doc/BRIEF.md
# Universal bidirectional shift register

This block is a synchronous register of parameterizable width, eight bits by default. A two-bit operation code is sampled on every clock edge. It picks one of four actions: keep the stored word, move every bit one place toward the LSB, move every bit one place toward the MSB, or take a whole parallel word in one cycle. Each shift direction has its own serial input. Both end bits of the word are brought out as serial taps, and the full word is available in parallel at all times.

A synchronous clear overrides every operation code and empties the register. The block can be used as a serializer in either bit order, a deserializer, a delay line, or a multiply/divide-by-two stage.

Top module: `usr_shift_reg`

## Requirements
- R1: With op_sel = 2'b00 and clr low, the stored word is unchanged after the clock edge, whatever par_in and the serial inputs do.
- R2: With op_sel = 2'b10 and clr low, each bit moves one place toward the LSB on the edge. Bit W-1 takes ser_in_dn and the old bit 0 is discarded.
- R3: With op_sel = 2'b01 and clr low, each bit moves one place toward the MSB on the edge, doubling the value modulo 2^W. Bit 0 takes ser_in_up and the old bit W-1 is discarded. Example: 8'h03 becomes 8'h0C after two such edges.
- R4: With op_sel = 2'b11 and clr low, the word on par_in is stored on the edge.
- R5: When clr is high at an edge, the stored word and all outputs are zero after that edge, for every op_sel value.
- R6: tap_msb always equals bit W-1 of q_out, and tap_lsb always equals bit 0.
- R7: The serial input not used by the current operation has no effect: ser_in_up has no effect while shifting toward the LSB, and ser_in_dn has no effect while shifting toward the MSB.
- R8: A single 1 loaded at bit 0 and shifted toward the MSB with zeros entering reaches tap_msb after exactly W-1 edges and leaves the word all zero after W edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| op_sel | input | 2 | Operation: 00 keep, 01 toward MSB, 10 toward LSB, 11 parallel load |
| par_in | input | W | Parallel word used by the load operation |
| ser_in_dn | input | 1 | Serial bit entering at the MSB when shifting toward the LSB |
| ser_in_up | input | 1 | Serial bit entering at the LSB when shifting toward the MSB |
| q_out | output | W | Stored word |
| tap_msb | output | 1 | Serial tap at the MSB end |
| tap_lsb | output | 1 | Serial tap at the LSB end |

## Verification
The hardest case to provoke is a collision: clr asserted in the same cycle as a load, or during a shift whose unused serial input is toggling. In that cycle three sources compete for the next word. The stimulus applies clear together with each of the four operation codes, right after the register was loaded with a non-zero word, so a wrong priority shows up as a non-zero word. Runs of shifts drive the serial input of the other direction to the opposite value of the active one, so any leak of the wrong input shows up at the taps.

// File: rtl/usr_pkg.sv
package usr_pkg;

    // Operation code values seen on op_sel
    typedef enum logic [1:0] {
        OP_KEEP = 2'b00,
        OP_UP   = 2'b01,
        OP_DN   = 2'b10,
        OP_LOAD = 2'b11
    } op_e;

    // Positions in the decoded one-hot action vector
    localparam int ACT_KEEP = 0;
    localparam int ACT_UP   = 1;
    localparam int ACT_DN   = 2;
    localparam int ACT_LOAD = 3;
    localparam int ACT_N    = 4;

endpackage

// File: rtl/usr_op_decode.sv
module usr_op_decode
    import usr_pkg::*;
(
    input  logic              clr,
    input  logic [1:0]        op_sel,
    output logic [ACT_N-1:0]  act_oh
);

    op_e op_c;

    always_comb begin
        op_c   = op_e'(op_sel);
        act_oh = '0;
        // Clear wins: no action selected, so every next bit is zero
        if (!clr) begin
            unique case (op_c)
                OP_KEEP: act_oh[ACT_KEEP] = 1'b1;
                OP_UP:   act_oh[ACT_UP]   = 1'b1;
                OP_DN:   act_oh[ACT_DN]   = 1'b1;
                OP_LOAD: act_oh[ACT_LOAD] = 1'b1;
                default: act_oh = '0;
            endcase
        end
    end

endmodule

// File: rtl/usr_next_word.sv
module usr_next_word
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      cur_word,
    input  logic [W-1:0]      par_word,
    input  logic              bit_from_dn,
    input  logic              bit_from_up,
    input  logic [ACT_N-1:0]  act_oh,
    output logic [W-1:0]      nxt_word
);

    localparam int MSB = W - 1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic lower_nb;   // source when moving toward the MSB
        logic upper_nb;   // source when moving toward the LSB

        if (i == 0) begin : g_lo_end
            assign lower_nb = bit_from_up;
        end else begin : g_lo_mid
            assign lower_nb = cur_word[i-1];
        end

        if (i == MSB) begin : g_hi_end
            assign upper_nb = bit_from_dn;
        end else begin : g_hi_mid
            assign upper_nb = cur_word[i+1];
        end

        assign nxt_word[i] = (act_oh[ACT_KEEP] & cur_word[i])
                           | (act_oh[ACT_UP]   & lower_nb)
                           | (act_oh[ACT_DN]   & upper_nb)
                           | (act_oh[ACT_LOAD] & par_word[i]);
    end

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
    import usr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          clr,
    input  logic [1:0]    op_sel,
    input  logic [W-1:0]  par_in,
    input  logic          ser_in_dn,
    input  logic          ser_in_up,
    output logic [W-1:0]  q_out,
    output logic          tap_msb,
    output logic          tap_lsb
);

    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] word;
    } state_t;

    state_t st_d;
    state_t st_q;

    logic [ACT_N-1:0] act_oh;
    logic [W-1:0]     nxt_word;

    usr_op_decode u_dec (
        .clr    (clr),
        .op_sel (op_sel),
        .act_oh (act_oh)
    );

    usr_next_word #(.W(W)) u_nxt (
        .cur_word    (st_q.word),
        .par_word    (par_in),
        .bit_from_dn (ser_in_dn),
        .bit_from_up (ser_in_up),
        .act_oh      (act_oh),
        .nxt_word    (nxt_word)
    );

    always_comb begin
        st_d      = st_q;
        st_d.word = nxt_word;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign q_out   = st_q.word;
    assign tap_msb = st_q.word[MSB];
    assign tap_lsb = st_q.word[0];

endmodule

// File: rtl/usr_sva.sv
module usr_sva #(
    parameter int W = 8
) (
    input logic          clk,
    input logic          clr,
    input logic [1:0]    op_sel,
    input logic [W-1:0]  par_in,
    input logic          ser_in_dn,
    input logic          ser_in_up,
    input logic [W-1:0]  q_out,
    input logic          tap_msb,
    input logic          tap_lsb
);

    AST_CLEAR_ZERO: assert property (@(posedge clk)
        clr |=> (q_out == '0) && !tap_msb && !tap_lsb);  // R5

    AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 2'b00) |=> $stable(q_out));  // R1

    AST_SHIFT_DN: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 2'b10) |=> q_out == {$past(ser_in_dn), $past(q_out[W-1:1])});  // R2

    AST_SHIFT_UP: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 2'b01) |=> q_out == {$past(q_out[W-2:0]), $past(ser_in_up)});  // R3

    AST_LOAD_WORD: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 2'b11) |=> q_out == $past(par_in));  // R4

    AST_TAP_MSB_MOVE: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 2'b01) |=> tap_msb == $past(q_out[W-2]));  // R6

    AST_TAP_LSB_MOVE: assert property (@(posedge clk) disable iff (clr)
        (op_sel == 2'b10) |=> tap_lsb == $past(q_out[1]));  // R6

endmodule

bind usr_shift_reg usr_sva #(.W(W)) u_sva (
    .clk       (clk),
    .clr       (clr),
    .op_sel    (op_sel),
    .par_in    (par_in),
    .ser_in_dn (ser_in_dn),
    .ser_in_up (ser_in_up),
    .q_out     (q_out),
    .tap_msb   (tap_msb),
    .tap_lsb   (tap_lsb)
);

// File: tb/usr_shift_reg_tb_top.sv
module usr_shift_reg_tb_top;

    localparam int W       = 8;
    localparam int CLK_PER = 10;

    logic          clk = 1'b0;
    logic          clr;
    logic [1:0]    op_sel;
    logic [W-1:0]  par_in;
    logic          ser_in_dn;
    logic          ser_in_up;
    logic [W-1:0]  q_out;
    logic          tap_msb;
    logic          tap_lsb;

    int n_chk = 0;
    int n_bad = 0;

    typedef struct {
        logic [W-1:0] exp_q;
        string        tag;
    } exp_t;

    exp_t         sb_q[$];
    logic [W-1:0] model;

    always #(CLK_PER/2) clk = ~clk;

    usr_shift_reg #(.W(W)) dut_i (
        .clk       (clk),
        .clr       (clr),
        .op_sel    (op_sel),
        .par_in    (par_in),
        .ser_in_dn (ser_in_dn),
        .ser_in_up (ser_in_up),
        .q_out     (q_out),
        .tap_msb   (tap_msb),
        .tap_lsb   (tap_lsb)
    );

    // Driver: apply one cycle of stimulus, predict from the requirements
    task automatic step(input logic c, input logic [1:0] op, input logic [W-1:0] d,
                        input logic dn, input logic up, input string tag);
        exp_t e;
        @(negedge clk);
        clr = c; op_sel = op; par_in = d; ser_in_dn = dn; ser_in_up = up;
        if (c)               model = '0;
        else if (op == 2'b01) model = {model[W-2:0], up};
        else if (op == 2'b10) model = {dn, model[W-1:1]};
        else if (op == 2'b11) model = d;
        e.exp_q = model;
        e.tag   = tag;
        sb_q.push_back(e);
    endtask

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compare just after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                check(e.tag, q_out, e.exp_q);
                check("R6 msb", {{(W-1){1'b0}}, tap_msb}, {{(W-1){1'b0}}, e.exp_q[W-1]});
                check("R6 lsb", {{(W-1){1'b0}}, tap_lsb}, {{(W-1){1'b0}}, e.exp_q[0]});
            end
        end
    end

    initial begin
        #(CLK_PER * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        clr = 1'b1; op_sel = 2'b11; par_in = '1; ser_in_dn = 1'b1; ser_in_up = 1'b1;
        model = '0;
        // R5: reset state, clear beats a load
        step(1, 2'b11, 8'hFF, 1, 1, "R5 clr+load");
        // R4 then R3: 03 doubled twice is 0C
        step(0, 2'b11, 8'h03, 0, 0, "R4 load");
        step(0, 2'b01, 8'h00, 1, 0, "R3 up1");
        step(0, 2'b01, 8'h00, 1, 0, "R3 up2");
        if (model != 8'h0C) $display("FAIL R3 model actual=%h expected=0c", model);
        // R1: keep while every other input toggles
        step(0, 2'b00, 8'hFF, 1, 1, "R1 keep");
        step(0, 2'b00, 8'h55, 0, 1, "R1 keep");
        step(0, 2'b00, 8'hAA, 1, 0, "R1 keep");
        // R2 and R7: shift toward LSB, ser_in_up held opposite
        step(0, 2'b11, 8'hA5, 0, 0, "R4 load");
        for (int i = 0; i < W; i++)
            step(0, 2'b10, 8'h00, i[0], ~i[0], "R2 R7 dn");
        // R3 and R7: shift toward MSB, ser_in_dn held opposite
        for (int i = 0; i < W; i++)
            step(0, 2'b01, 8'hFF, ~i[1], i[1], "R3 R7 up");
        // R8: a single 1 walks from bit 0 to the MSB tap
        step(0, 2'b11, 8'h01, 0, 0, "R4 load");
        for (int i = 0; i < W; i++)
            step(0, 2'b01, 8'h00, 1, 0, "R8 walk");
        // R5: clear against every operation code after a non-zero load
        for (int op = 0; op < 4; op++) begin
            step(0, 2'b11, 8'hC3, 1, 1, "R4 load");
            step(1, op[1:0], 8'h7E, 1, 1, "R5 clr prio");
        end
        // R5: clear held across several cycles
        step(1, 2'b10, 8'h00, 1, 1, "R5 clr hold");
        step(0, 2'b10, 8'h00, 1, 0, "R2 after clr");
        @(posedge clk);
        #2;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule